// File: doc/BRIEF.md
# Voice Envelope Generator

This block shapes the loudness of one synthesizer voice. It holds an 11-bit envelope level and moves it once per audio sample, on a one-cycle `tick` pulse. The level follows either a four-phase contour (rise, fall to a hold level, slow fade, and a final fade after the note is released) or one of several directly programmed gain behaviours: a fixed level, a linear fall, an exponential fall, a linear rise, or a rise that slows near the top.

A note is started with a `key_on` pulse and ended with a `key_off` pulse. Either pulse may arrive on any clock cycle. It is held until the next tick, and all key handling is done at that tick. Step rates are 5-bit codes. Each code selects a period in samples, measured against a shared sample counter that starts at reset. A 7-bit coarse readback of the level is provided for status reads.

Top module: `adsr_envelope`

## Requirements
- R1: After reset the envelope and the readback are 0, the voice is in the release phase, and the sample counter index is 0.
- R2: Key pulses are held until the next tick, or taken on the tick cycle itself. At that tick a key-on sets the envelope to 0 and enters the attack phase, with no other step. A key-off alone enters release and applies the release step in the same tick. Both together leave the envelope at 0 in release.
- R3: In release, every tick lowers the envelope by 8, with a floor of 0. This holds for any mode or rate setting.
- R4: `set_a[7]`=1 selects the four-phase contour. In attack, attack field `set_a[3:0]`=15 adds 1024 at rate 31, and any other value adds 32 at rate {A,1}. The result saturates at $7FF. The unsaturated sum reaching $7FF enters decay.
- R5: Decay applies the exponential step at rate {1,`set_a[6:4]`,0}. After each decay tick, if envelope>>8 equals `set_b[7:5]`, the phase becomes sustain.
- R6: Sustain applies the exponential step at rate `set_b[4:0]` and stays there until a key event. The exponential step maps e to e-1-((e-1)>>8), and 0 stays at 0.
- R7: With `set_a[7]`=0 and `gain_cfg[7]`=0, each tick outside release sets the envelope to `gain_cfg[6:0]`×16.
- R8: With `set_a[7]`=0 and `gain_cfg[7]`=1, the mode is `gain_cfg[6:5]` and the rate is `gain_cfg[4:0]`. Mode 00 subtracts 32 with a floor of 0. Mode 01 applies the exponential step. Mode 10 adds 32. Mode 11 adds 32 below $600 and 8 from $600 up. Rises saturate at $7FF.
- R9: Rate 0 never steps. For rates 1..31 the periods are 2048,1536,1280,1024,768,640,512,384,320,256,192,160,128,96,80,64,48,40,32,24,20,16,12,10,8,6,5,4,3,2,1. Ticks are numbered from 0 after reset, and a rate steps on a tick whose number is a multiple of its period.
- R10: The readback `env_rb` equals envelope bits 10..4.
- R11: The envelope changes on no cycle other than a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per audio sample |
| key_on | input | 1 | Note start pulse |
| key_off | input | 1 | Note release pulse |
| set_a | input | 8 | Contour enable, decay rate, attack rate |
| set_b | input | 8 | Sustain level and sustain rate |
| gain_cfg | input | 8 | Direct gain mode, value or rate |
| env | output | 11 | Envelope level |
| env_rb | output | 7 | Coarse envelope readback |

## Verification
The assertions assume that `tick` is a single-cycle pulse, and that the settings bytes hold steady on the tick cycle that steps with them. The stimulus raises `tick` for exactly one cycle per sample. It changes `set_a`, `set_b` and `gain_cfg` only on cycles with no tick. Key pulses are driven either one cycle ahead of a tick or on the tick itself, so both the held path and the direct path are covered.

// File: rtl/adsr_envelope.sv
module adsr_envelope #(
  parameter int EW = 11,
  parameter int RBW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          key_on,
  input  logic          key_off,
  input  logic [7:0]    set_a,
  input  logic [7:0]    set_b,
  input  logic [7:0]    gain_cfg,
  output logic [EW-1:0] env,
  output logic [RBW-1:0] env_rb
);
  localparam int CW = 11;
  localparam logic [EW+1:0] TOP  = (EW+2)'((1 << EW) - 1);
  localparam logic [EW-1:0] BEND = EW'(3 << (EW - 2));

  typedef enum logic [1:0] {ATT, DEC, SUS, REL} phase_t;

  phase_t        ph, nph;
  logic [EW-1:0] nxt;
  logic          pend_on, pend_off;
  logic [CW-1:0] bin;
  logic [1:0]    m3;
  logic [2:0]    m5;

  wire g_on  = pend_on | key_on;
  wire g_off = pend_off | key_off;

  function automatic logic hit(input logic [4:0] r);
    logic [5:0]  kf;
    logic [CW:0] mask;
    case (r)
      5'd1:  kf = {4'd11, 2'd0};
      5'd2:  kf = {4'd9,  2'd1};
      5'd3:  kf = {4'd8,  2'd2};
      5'd4:  kf = {4'd10, 2'd0};
      5'd5:  kf = {4'd8,  2'd1};
      5'd6:  kf = {4'd7,  2'd2};
      5'd7:  kf = {4'd9,  2'd0};
      5'd8:  kf = {4'd7,  2'd1};
      5'd9:  kf = {4'd6,  2'd2};
      5'd10: kf = {4'd8,  2'd0};
      5'd11: kf = {4'd6,  2'd1};
      5'd12: kf = {4'd5,  2'd2};
      5'd13: kf = {4'd7,  2'd0};
      5'd14: kf = {4'd5,  2'd1};
      5'd15: kf = {4'd4,  2'd2};
      5'd16: kf = {4'd6,  2'd0};
      5'd17: kf = {4'd4,  2'd1};
      5'd18: kf = {4'd3,  2'd2};
      5'd19: kf = {4'd5,  2'd0};
      5'd20: kf = {4'd3,  2'd1};
      5'd21: kf = {4'd2,  2'd2};
      5'd22: kf = {4'd4,  2'd0};
      5'd23: kf = {4'd2,  2'd1};
      5'd24: kf = {4'd1,  2'd2};
      5'd25: kf = {4'd3,  2'd0};
      5'd26: kf = {4'd1,  2'd1};
      5'd27: kf = {4'd0,  2'd2};
      5'd28: kf = {4'd2,  2'd0};
      5'd29: kf = {4'd0,  2'd1};
      5'd30: kf = {4'd1,  2'd0};
      default: kf = {4'd0, 2'd0};
    endcase
    mask = (CW+1)'((12'd1 << kf[5:2]) - 12'd1);
    return (r != 5'd0) && (({1'b0, bin} & mask) == '0)
           && (kf[1:0] != 2'd1 || m3 == 2'd0)
           && (kf[1:0] != 2'd2 || m5 == 3'd0);
  endfunction

  function automatic logic [EW-1:0] rise(input logic [EW-1:0] e, input logic [EW+1:0] amt);
    logic [EW+1:0] s;
    s = {2'b00, e} + amt;
    return (s > TOP) ? TOP[EW-1:0] : s[EW-1:0];
  endfunction

  function automatic logic [EW-1:0] fall(input logic [EW-1:0] e, input logic [EW-1:0] amt);
    return (e >= amt) ? e - amt : '0;
  endfunction

  logic [EW-1:0] em1, exp_dn;
  logic [EW+1:0] att_sum;
  logic [4:0]    att_rate;

  assign em1      = env - 1'b1;
  assign exp_dn   = (env == '0) ? '0 : em1 - (em1 >> 8);
  assign att_rate = (set_a[3:0] == 4'hF) ? 5'd31 : {set_a[3:0], 1'b1};
  assign att_sum  = {2'b00, env} + ((set_a[3:0] == 4'hF) ? (EW+2)'(1024) : (EW+2)'(32));
  assign env_rb   = env[EW-1 -: RBW];

  always_comb begin
    nxt = env;
    nph = ph;
    if (g_on) begin
      nxt = '0;
      nph = g_off ? REL : ATT;
    end else if (g_off || ph == REL) begin
      nph = REL;
      nxt = fall(env, EW'(8));
    end else if (set_a[7]) begin
      case (ph)
        ATT: if (hit(att_rate)) begin
          nxt = (att_sum > TOP) ? TOP[EW-1:0] : att_sum[EW-1:0];
          if (att_sum >= TOP) nph = DEC;
        end
        DEC: begin
          if (hit({1'b1, set_a[6:4], 1'b0})) nxt = exp_dn;
          if (nxt[EW-1:EW-3] == set_b[7:5]) nph = SUS;
        end
        default: if (hit(set_b[4:0])) nxt = exp_dn;
      endcase
    end else if (!gain_cfg[7]) begin
      nxt = EW'(gain_cfg[6:0]) << (EW - 7);
    end else if (hit(gain_cfg[4:0])) begin
      case (gain_cfg[6:5])
        2'b00:   nxt = fall(env, EW'(32));
        2'b01:   nxt = exp_dn;
        2'b10:   nxt = rise(env, (EW+2)'(32));
        default: nxt = rise(env, (env < BEND) ? (EW+2)'(32) : (EW+2)'(8));
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env      <= '0;
      ph       <= REL;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
      bin      <= '0;
      m3       <= '0;
      m5       <= '0;
    end else if (tick) begin
      env      <= nxt;
      ph       <= nph;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
      bin      <= bin + 1'b1;
      m3       <= (m3 == 2'd2) ? 2'd0 : m3 + 2'd1;
      m5       <= (m5 == 3'd4) ? 3'd0 : m5 + 3'd1;
    end else begin
      pend_on  <= g_on;
      pend_off <= g_off;
    end
  end

  // R11
  env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(env));

  // R2
  kon_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && g_on) |=> env == '0);

  // R2
  both_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && g_on && g_off) |=> ph == REL);

  // R3
  rel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ph == REL && !g_on) |=>
      env == (($past(env) >= EW'(8)) ? $past(env) - EW'(8) : '0));

  // R7
  gain_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !g_on && !g_off && ph != REL && !set_a[7] && !gain_cfg[7]) |=>
      env == (EW'($past(gain_cfg[6:0])) << (EW - 7)));

  // R9
  rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !g_on && !g_off && ph != REL && !set_a[7] && gain_cfg[7] &&
     gain_cfg[4:0] == 5'd0) |=> $stable(env));
endmodule

// File: tb/tb_adsr_envelope.sv
module tb_adsr_envelope;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, key_on = 0, key_off = 0;
  logic [7:0] set_a = 0, set_b = 0, gain_cfg = 0;
  logic [10:0] env;
  logic [6:0] env_rb;

  int vectors = 0, errors = 0, cycles = 0;
  int m_env = 0, m_ph = 3, n = 0;
  string tag;

  adsr_envelope dut (.clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on),
    .key_off(key_off), .set_a(set_a), .set_b(set_b), .gain_cfg(gain_cfg),
    .env(env), .env_rb(env_rb));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period(int r);
    case (r)
      1: return 2048; 2: return 1536; 3: return 1280; 4: return 1024;
      5: return 768;  6: return 640;  7: return 512;  8: return 384;
      9: return 320;  10: return 256; 11: return 192; 12: return 160;
      13: return 128; 14: return 96;  15: return 80;  16: return 64;
      17: return 48;  18: return 40;  19: return 32;  20: return 24;
      21: return 20;  22: return 16;  23: return 12;  24: return 10;
      25: return 8;   26: return 6;   27: return 5;   28: return 4;
      29: return 3;   30: return 2;   default: return 1;
    endcase
  endfunction

  function automatic bit fires(int r);
    return r != 0 && (n % period(r)) == 0;
  endfunction

  function automatic int expd(int e);
    return e == 0 ? 0 : e - 1 - ((e - 1) >> 8);
  endfunction

  function automatic void mstep(bit kon, bit koff);
    int s, r;
    if (kon) begin
      m_env = 0; m_ph = koff ? 3 : 0; tag = "R2";
    end else if (koff || m_ph == 3) begin
      m_ph = 3; m_env = m_env > 8 ? m_env - 8 : 0; tag = koff ? "R2" : "R3";
    end else if (set_a[7]) begin
      if (m_ph == 0) begin
        tag = "R4";
        r = set_a[3:0] == 15 ? 31 : int'(set_a[3:0]) * 2 + 1;
        if (fires(r)) begin
          s = m_env + (set_a[3:0] == 15 ? 1024 : 32);
          if (s >= 2047) m_ph = 1;
          m_env = s > 2047 ? 2047 : s;
        end
      end else if (m_ph == 1) begin
        tag = "R5";
        if (fires(16 + int'(set_a[6:4]) * 2)) m_env = expd(m_env);
        if ((m_env >> 8) == int'(set_b[7:5])) m_ph = 2;
      end else begin
        tag = "R6";
        if (fires(int'(set_b[4:0]))) m_env = expd(m_env);
      end
    end else if (!gain_cfg[7]) begin
      tag = "R7"; m_env = int'(gain_cfg[6:0]) * 16;
    end else begin
      tag = "R8";
      if (fires(int'(gain_cfg[4:0])))
        case (gain_cfg[6:5])
          2'b00: m_env = m_env > 32 ? m_env - 32 : 0;
          2'b01: m_env = expd(m_env);
          2'b10: m_env = m_env + 32 > 2047 ? 2047 : m_env + 32;
          default: begin
            s = m_env + (m_env < 'h600 ? 32 : 8);
            m_env = s > 2047 ? 2047 : s;
          end
        endcase
    end
    n++;
  endfunction

  task automatic check(string t);
    vectors++;
    if (int'(env) != m_env) begin
      errors++;
      $display("FAIL %s env actual=%0h expected=%0h", t, env, m_env);
    end
    vectors++;
    if (int'(env_rb) != (m_env >> 4)) begin
      errors++;
      $display("FAIL R10 readback actual=%0h expected=%0h", env_rb, m_env >> 4);
    end
  endtask

  task automatic sample(bit kon, bit koff, bit early, string t = "");
    if (early) begin
      @(negedge clk); key_on = kon; key_off = koff;
      @(negedge clk); key_on = 0; key_off = 0;
      @(negedge clk); tick = 1;
    end else begin
      @(negedge clk); tick = 1; key_on = kon; key_off = koff;
    end
    @(negedge clk); tick = 0; key_on = 0; key_off = 0;
    mstep(kon, koff);
    check(t == "" ? tag : t);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");

    // R7 fixed gain after key-on; release ignores settings before that (R3)
    gain_cfg = 8'h7F;
    sample(0, 0, 0, "R3");
    sample(1, 0, 1, "R2");
    sample(0, 0, 0, "R7");
    gain_cfg = 8'h25;
    sample(0, 0, 1, "R7");

    // R11 idle cycles do not move env
    repeat (5) @(negedge clk);
    check("R11");

    // R3 release from a high level with fast gain rise selected
    gain_cfg = 8'h7F;
    sample(0, 0, 0, "R7");
    gain_cfg = 8'hDF;
    sample(0, 1, 0, "R3");
    for (int i = 0; i < 6; i++) sample(0, 0, 0, "R3");

    // R2 both pulses together
    sample(1, 1, 1, "R2");
    sample(0, 0, 0, "R3");

    // R4 fastest attack, then R5 decay and R6 sustain
    set_a = 8'hFF; set_b = 8'hBF;
    sample(1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) sample(0, 0, 0, "R4");
    for (int i = 0; i < 40; i++) sample(0, 0, 0, "R5");
    for (int i = 0; i < 40; i++) sample(0, 0, 0, "R6");
    set_a = 8'h8A;
    sample(1, 0, 1, "R2");
    for (int i = 0; i < 200; i++) sample(0, 0, 0, "R4");

    // R9 rate 0 hold and a mid rate
    set_a = 8'h00; gain_cfg = 8'h40;
    sample(0, 0, 0, "R7");
    gain_cfg = 8'hC0;
    for (int i = 0; i < 10; i++) sample(0, 0, 0, "R9");
    gain_cfg = 8'hDA;
    for (int i = 0; i < 30; i++) sample(0, 0, 0, "R9");
    gain_cfg = 8'hFE;
    for (int i = 0; i < 80; i++) sample(0, 0, 0, "R8");
    gain_cfg = 8'hBD;
    for (int i = 0; i < 80; i++) sample(0, 0, 0, "R8");

    // random mix
    for (int i = 0; i < 18000; i++) begin
      bit kon, koff;
      if ($urandom_range(0, 199) == 0) begin
        set_a = 8'($urandom); set_b = 8'($urandom); gain_cfg = 8'($urandom);
        if ($urandom_range(0, 1) == 1) begin
          set_a[3:0] = 4'($urandom_range(10, 15));
          gain_cfg[4:0] = 5'($urandom_range(18, 31));
          set_b[4:0] = 5'($urandom_range(16, 31));
        end
      end
      kon  = $urandom_range(0, 299) == 0;
      koff = $urandom_range(0, 299) == 0;
      sample(kon, koff, $urandom_range(0, 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule